// File: doc/BRIEF.md
# Paged Nonvolatile Write Sequencer

This block models the write path of a byte-wide paged nonvolatile store. Its strobes and buses are already synchronised to `clk`. A write pulse is qualified by active-low chip select, write strobe and output enable. Each pulse places one byte into a sector-sized staging buffer. Once the host stops starting new pulses for a set number of cycles, the block commits the staged sector. It does this in one timed erase-and-program period, during which `busy` is high and the buses are free for other traffic. The committed sector gets the staged bytes, and every byte of it that was not staged is set to 0xFF.

The address splits into a sector number in the upper bits and a byte offset in the lowest `PAGE_W` bits. With the defaults (`PAGE_W` = 7) a sector is 128 bytes. The full-size part is `ADDR_W` = 17, which gives 1024 sectors. The default `ADDR_W` = 11 keeps the behavioural array small. The load window (`LOAD_WIN`) and the program time (`PROG_CYC`) are counted in clock cycles. A read port returns stored bytes, so the effect of a commit can be seen at the pins.

Top module: `sector_writer`

## Requirements
- R1: After reset, `busy` and `sect_err` are 0 and every stored byte reads as 0xFF.
- R2: While cs_n=0, oe_n=0 and we_n=1, `dout` shows the stored byte at `addr`. In every other case `dout` is 0x00.
- R3: A write pulse needs oe_n=1 with cs_n and we_n both low. The address is taken in the first cycle in which both are low, which is the later of the two falling edges. The data is taken in the first cycle in which either of them is high again.
- R4: The bytes of a sector may be staged in any order. Each byte lands at the offset given by `addr[PAGE_W-1:0]`.
- R5: `busy` rises exactly `LOAD_WIN` cycles after the clock edge that captured the last byte, provided no new pulse starts in that time. A pulse that starts within the window extends the window.
- R6: `busy` stays high for exactly `PROG_CYC` cycles. The stored data changes only on the edge where `busy` falls.
- R7: A commit rewrites the whole sector. Staged offsets get their data and all other offsets of that sector read 0xFF.
- R8: A pulse with oe_n low when it starts, or one in which oe_n goes low before the strobes rise, stages nothing and opens no window.
- R9: If a byte arrives during an open window with a sector number that differs from the window's first byte, `sect_err` is set and stays set until reset. The byte is staged at its offset within the first sector.
- R10: Pulses that begin while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Byte address: sector number above offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0x00 when not reading |
| busy | output | 1 | High during the program period |
| sect_err | output | 1 | Sticky flag for a sector change within one window |

## Verification
Some properties are checked on every cycle: the program period never runs longer than `PROG_CYC`, and a steady read never sees stored data change except on the edge where `busy` falls. They also check that `sect_err` never clears, and that the staging state does not move while `busy` is high. Other behaviour only the bench scenarios can show. These cover the exact cycle on which the window expires, latching of address and data under chip-select-controlled pulses, and 0xFF fill of unstaged offsets on a rewrite. They also cover discarding pulses that are blocked by output enable, and where a byte lands when its sector disagrees with the window.

// File: rtl/sector_writer.sv
module sector_writer #(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 7,
  parameter int LOAD_WIN = 37500,
  parameter int PROG_CYC = 2500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              busy,
  output logic              sect_err
);
  localparam int PAGE   = 1 << PAGE_W;
  localparam int SECT_W = ADDR_W - PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WW     = $clog2(LOAD_WIN + 1);
  localparam int PW     = $clog2(PROG_CYC + 1);

  logic [7:0]        mem  [DEPTH];
  logic [7:0]        sbuf [PAGE];
  logic [PAGE-1:0]   vld;
  logic [SECT_W-1:0] sect;
  logic [ADDR_W-1:0] alat;
  logic [WW-1:0]     wcnt;
  logic [PW-1:0]     pcnt;
  logic              act_q, pend, loading;

  wire act    = !cs_n && !we_n && oe_n;
  wire start  = act && !act_q && !busy;
  wire fin    = pend && !act;
  wire take   = fin && oe_n;
  wire [PAGE_W-1:0] off  = alat[PAGE_W-1:0];
  wire [SECT_W-1:0] asec = alat[ADDR_W-1:PAGE_W];

  assign dout = (!cs_n && !oe_n && we_n) ? mem[addr] : 8'h00;

  always_ff @(posedge clk)
    if (take) sbuf[off] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      pend     <= 1'b0;
      loading  <= 1'b0;
      busy     <= 1'b0;
      sect_err <= 1'b0;
      wcnt     <= '0;
      pcnt     <= '0;
      alat     <= '0;
      sect     <= '0;
      vld      <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      act_q <= act;
      if (start) begin
        pend <= 1'b1;
        alat <= addr;
      end
      if (fin) begin
        pend <= 1'b0;
        if (oe_n) begin
          wcnt <= '0;
          if (!loading) begin
            loading  <= 1'b1;
            sect     <= asec;
            vld      <= '0;
            vld[off] <= 1'b1;
          end else begin
            vld[off] <= 1'b1;
            if (asec != sect) sect_err <= 1'b1;
          end
        end
      end else if (loading && !pend && !start) begin
        if (wcnt == WW'(LOAD_WIN - 1)) begin
          loading <= 1'b0;
          busy    <= 1'b1;
          pcnt    <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
      if (busy) begin
        if (pcnt == PW'(PROG_CYC - 1)) begin
          busy <= 1'b0;
          for (int i = 0; i < PAGE; i++)
            mem[{sect, PAGE_W'(i)}] <= vld[i] ? sbuf[i] : 8'hFF;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end
endmodule

module sector_writer_chk #(
  parameter int ADDR_W   = 11,
  parameter int PAGE     = 128,
  parameter int PROG_CYC = 2500000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dout,
  input logic              busy,
  input logic              sect_err,
  input logic [PAGE-1:0]   vld
);
  logic [31:0] blen;
  wire rd = !cs_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) blen <= '0;
    else        blen <= busy ? blen + 1 : '0;

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (blen < PROG_CYC));

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && $past(rd) && !busy && !$past(busy) && $stable(addr)) |-> $stable(dout));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sect_err |=> sect_err);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vld));
endmodule

bind sector_writer sector_writer_chk #(.ADDR_W(ADDR_W), .PAGE(PAGE), .PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
  .addr(addr), .dout(dout), .busy(busy), .sect_err(sect_err), .vld(vld)
);

// File: tb/sector_writer_tb.sv
module sector_writer_tb;
  localparam int AW = 11;
  localparam int LW = 16;
  localparam int PC = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic busy, sect_err;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  sector_writer #(.ADDR_W(AW), .PAGE_W(7), .LOAD_WIN(LW), .PROG_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .sect_err(sect_err));

  // {offset, data}, loaded into sector 3 out of order
  localparam logic [14:0] VEC [8] = '{
    {7'd100, 8'hA1}, {7'd3, 8'h3C}, {7'd127, 8'h00}, {7'd0, 8'h5E},
    {7'd64, 8'hC7}, {7'd1, 8'h12}, {7'd90, 8'hFE}, {7'd33, 8'h81}};

  function automatic logic [AW-1:0] ad(int s, int o);
    return AW'(s * 128 + o);
  endfunction

  task automatic chk(string req, logic [31:0] a, logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, a, e);
    end
  endtask

  task automatic load(logic [AW-1:0] a, logic [7:0] d);
    cs_n = 0; we_n = 0; oe_n = 1; addr = a; din = 8'h5A;
    @(negedge clk);
    cs_n = 1; we_n = 1; din = d;
    @(negedge clk);
    din = 8'hC3;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
    cs_n = 0; oe_n = 0; we_n = 1; addr = a;
    #1 v = dout;
    @(negedge clk);
    cs_n = 1; oe_n = 1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic commit;
    idle(LW + PC + 2);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL R6 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int seen;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 err", sect_err, 0);
    rd(ad(3, 100), v); chk("R1 erased", v, 8'hFF);
    rd(ad(15, 127), v); chk("R1 erased top", v, 8'hFF);
    #1 chk("R2 idle dout", dout, 8'h00);

    for (int i = 0; i < 8; i++) load(ad(3, int'(VEC[i][14:8])), VEC[i][7:0]);
    idle(LW - 1); chk("R5 before window", busy, 0);
    idle(1);      chk("R5 window expired", busy, 1);
    idle(PC - 1); chk("R6 still busy", busy, 1);
    idle(1);      chk("R6 done", busy, 0);
    for (int i = 0; i < 8; i++) begin
      rd(ad(3, int'(VEC[i][14:8])), v);
      chk("R4 table byte", v, {24'h0, VEC[i][7:0]});
    end
    rd(ad(3, 2), v);  chk("R7 unloaded", v, 8'hFF);
    rd(ad(4, 0), v);  chk("R7 other sector", v, 8'hFF);

    load(ad(3, 64), 8'hE1);
    commit;
    rd(ad(3, 64), v);  chk("R7 rewritten", v, 8'hE1);
    rd(ad(3, 100), v); chk("R7 old erased", v, 8'hFF);
    rd(ad(3, 1), v);   chk("R7 old erased", v, 8'hFF);

    // R3: chip-select-controlled pulse
    we_n = 0; cs_n = 1; oe_n = 1; addr = ad(5, 9); @(negedge clk);
    cs_n = 0; addr = ad(5, 4); @(negedge clk);
    addr = ad(5, 6); din = 8'h11; @(negedge clk);
    cs_n = 1; din = 8'hA7; @(negedge clk);
    we_n = 1; din = 8'h00; @(negedge clk);
    commit;
    rd(ad(5, 4), v); chk("R3 latched", v, 8'hA7);
    rd(ad(5, 9), v); chk("R3 early addr", v, 8'hFF);
    rd(ad(5, 6), v); chk("R3 late addr", v, 8'hFF);

    // R8: output enable low blocks
    seen = 0;
    oe_n = 0; cs_n = 0; we_n = 0; addr = ad(9, 1); @(negedge clk);
    cs_n = 1; we_n = 1; din = 8'h55; @(negedge clk);
    oe_n = 1; @(negedge clk);
    oe_n = 1; cs_n = 0; we_n = 0; addr = ad(9, 2); @(negedge clk);
    oe_n = 0; @(negedge clk);
    cs_n = 1; we_n = 1; din = 8'h66; @(negedge clk);
    oe_n = 1;
    for (int i = 0; i < LW + PC + 4; i++) begin @(negedge clk); if (busy) seen++; end
    chk("R8 no window", seen, 0);
    rd(ad(9, 1), v); chk("R8 oe low", v, 8'hFF);
    rd(ad(9, 2), v); chk("R8 oe drop", v, 8'hFF);

    // R9: sector change within a window
    chk("R9 clear", sect_err, 0);
    load(ad(6, 1), 8'h11);
    load(ad(7, 2), 8'h22);
    chk("R9 flagged", sect_err, 1);
    commit;
    rd(ad(6, 1), v); chk("R9 first", v, 8'h11);
    rd(ad(6, 2), v); chk("R9 kept sector", v, 8'h22);
    rd(ad(7, 2), v); chk("R9 other", v, 8'hFF);
    chk("R9 sticky", sect_err, 1);

    // R10: loads during busy ignored
    load(ad(10, 0), 8'h77);
    idle(LW + 2);
    chk("R10 busy", busy, 1);
    load(ad(8, 3), 8'h99);
    while (busy) @(negedge clk);
    seen = 0;
    for (int i = 0; i < LW + 6; i++) begin @(negedge clk); if (busy) seen++; end
    chk("R10 no second commit", seen, 0);
    rd(ad(8, 3), v);  chk("R10 ignored", v, 8'hFF);
    rd(ad(10, 0), v); chk("R10 first kept", v, 8'h77);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule